// File: doc/BRIEF.md
# Multiply-Divide Unit with Handshake

This block carries out the eight integer multiply and divide operations of a 32-bit RISC-V core that implements the M extension. The core presents two operands and a three-bit operation code. The unit returns one result word and holds it until the core acknowledges it. Multiplies produce their answer after a single state step. Divides run a restoring shift-and-subtract loop with one bit per clock, and that loop yields the quotient and the remainder together. Signed divides work on operand magnitudes and correct the signs at the end.

The core uses the `busy` output as one input of its global stall. It stays high from the cycle a request is presented to an idle unit until the cycle in which the result is acknowledged. A new request is taken only while the unit is idle. Anything presented at other times is ignored and has to be held by the requester.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `busy` is 0.
- R2: Operation code 0 (low multiply) returns the low 32 bits of the product of `req_a` and `req_b`. The result is the same whether the operands are read as signed or unsigned.
- R3: Operation codes 1, 2 and 3 return the upper 32 bits of the 64-bit product. Code 1 treats both operands as signed, code 2 treats `req_a` as signed and `req_b` as unsigned, and code 3 treats both as unsigned.
- R4: For a multiply accepted at a rising edge (idle and `req_valid` high), `rsp_valid` is already high in the cycle that follows that edge.
- R5: Code 4 returns the signed quotient rounded toward zero, code 5 the unsigned quotient, code 6 the signed remainder (it has the sign of the dividend), and code 7 the unsigned remainder.
- R6: For a divide accepted at a rising edge, `rsp_valid` first rises after the 32nd rising edge that follows the accepting edge. With XLEN set to 32 this is exactly XLEN iteration edges.
- R7: When the divisor is zero, codes 4 and 5 return all ones and codes 6 and 7 return the dividend unchanged.
- R8: For the signed overflow case 0x80000000 divided by 0xFFFFFFFF, code 4 returns 0x80000000 and code 6 returns 0.
- R9: While `rsp_valid` is high and `rsp_ack` is low, `rsp_valid` stays high and `rsp_data` does not change. After a cycle with both high, the unit is idle: `req_ready` is 1 and `rsp_valid` is 0.
- R10: `busy` is high in a cycle where the unit is idle and `req_valid` is high, and in every later cycle until the cycle with `rsp_valid` and `rsp_ack` both high, where it is low.
- R11: `req_ready` is high only while no operation is in flight. A request presented while `req_ready` is low does not change the result in flight or its timing. A request held across the acknowledge cycle is accepted at the second rising edge after the acknowledge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_op | input | 3 | Operation: 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU |
| req_a | input | 32 | First operand (dividend for divides) |
| req_b | input | 32 | Second operand (divisor for divides) |
| rsp_valid | output | 1 | Result available |
| rsp_data | output | 32 | Result word |
| rsp_ack | input | 1 | Requester takes the result |
| busy | output | 1 | Stall request to the core |

## Verification
The acknowledge of one result and the arrival of the next request can fall in the same cycle, because a core that has stalled on one operation presents the next one at once. The bench provokes this by keeping `req_valid` high with fresh operands all the way through each acknowledge, and it also dedicates one divide-then-multiply pair to it. In that pair it judges that the waiting request is taken only at the second edge after the acknowledge. It also judges that `busy` falls in the acknowledge cycle, and that the earlier result was neither corrupted nor extended. A separate burst of requests during a running divide confirms that they leave the division untouched.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // operation encoding follows the funct3 field of the M extension
  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL_DONE,
    ST_DIV_RUN,
    ST_DONE
  } md_state_e;

endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  md_op_e          op,
  output logic [XLEN-1:0] res
);

  localparam int PW = 2 * XLEN;

  logic               a_sgn, b_sgn;
  logic signed [PW-1:0] ext_a, ext_b, prod;

  always_comb begin
    a_sgn = (op == OP_MULH) || (op == OP_MULHSU);
    b_sgn = (op == OP_MULH);
    ext_a = {{XLEN{a_sgn & opa[XLEN-1]}}, opa};
    ext_b = {{XLEN{b_sgn & opb[XLEN-1]}}, opb};
    // product modulo 2^PW is exact for the sign-extended operands
    prod  = ext_a * ext_b;
    res   = (op == OP_MUL) ? prod[XLEN-1:0] : prod[PW-1:XLEN];
  end

endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic [XLEN-1:0] num,
  input  logic [XLEN-1:0] den,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem,
  output logic            last
);

  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;

  logic [XLEN-1:0] rem_q, quo_q, den_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   shifted, trial;
  logic            fits;

  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = ~trial[XLEN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= num;
      den_q <= den;
      cnt_q <= '0;
    end else if (step) begin
      rem_q <= fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      quo_q <= {quo_q[XLEN-2:0], fits};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign last = step && (cnt_q == CW'(XLEN - 1));

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (step && den_q != '0) |=> (rem_q < den_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [XLEN-1:0] req_a,
  input  logic [XLEN-1:0] req_b,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data,
  input  logic            rsp_ack,
  output logic            busy
);

  md_state_e       state_q, state_d;
  md_op_e          op_in;
  logic            accept, is_div, sgn_div, a_neg, b_neg;
  logic [XLEN-1:0] mag_a, mag_b, mul_out, mul_res_q, num_q;
  logic            neg_quo_q, neg_rem_q, want_rem_q, dz_q;
  logic [XLEN-1:0] dquo, drem, fix_quo, fix_rem, div_res;
  logic            div_last;

  always_comb begin
    op_in   = md_op_e'(req_op);
    is_div  = req_op[2];
    sgn_div = (op_in == OP_DIV) || (op_in == OP_REM);
    a_neg   = sgn_div & req_a[XLEN-1];
    b_neg   = sgn_div & req_b[XLEN-1];
    mag_a   = a_neg ? (~req_a + 1'b1) : req_a;
    mag_b   = b_neg ? (~req_b + 1'b1) : req_b;
    accept  = (state_q == ST_IDLE) && req_valid;
  end

  muldiv_mul #(.XLEN(XLEN)) u_mul (
    .opa (req_a),
    .opb (req_b),
    .op  (op_in),
    .res (mul_out)
  );

  muldiv_div #(.XLEN(XLEN)) u_div (
    .clk  (clk),
    .rst  (rst),
    .load (accept && is_div),
    .step (state_q == ST_DIV_RUN),
    .num  (mag_a),
    .den  (mag_b),
    .quo  (dquo),
    .rem  (drem),
    .last (div_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid) state_d = is_div ? ST_DIV_RUN : ST_MUL_DONE;
      ST_MUL_DONE: if (rsp_ack) state_d = ST_IDLE;
      ST_DIV_RUN:  if (div_last) state_d = ST_DONE;
      ST_DONE:     if (rsp_ack) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mul_res_q  <= '0;
      num_q      <= '0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      want_rem_q <= 1'b0;
      dz_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept && !is_div) mul_res_q <= mul_out;
      if (accept && is_div) begin
        num_q      <= req_a;
        neg_quo_q  <= a_neg ^ b_neg;
        neg_rem_q  <= a_neg;
        want_rem_q <= req_op[1];
        dz_q       <= (req_b == '0);
      end
    end
  end

  // sign fix-up and the zero-divisor override
  always_comb begin
    fix_quo = neg_quo_q ? (~dquo + 1'b1) : dquo;
    fix_rem = neg_rem_q ? (~drem + 1'b1) : drem;
    if (dz_q) begin
      fix_quo = '1;
      fix_rem = num_q;
    end
    div_res = want_rem_q ? fix_rem : fix_quo;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_MUL_DONE) || (state_q == ST_DONE);
  assign rsp_data  = (state_q == ST_MUL_DONE) ? mul_res_q :
                     (state_q == ST_DONE)     ? div_res   : '0;
  assign busy      = ((state_q == ST_IDLE) && req_valid) ||
                     ((state_q != ST_IDLE) && !(rsp_valid && rsp_ack));

  // R4
  mul_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !req_op[2]) |=> rsp_valid);

  // R6
  div_early_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && req_op[2]) |=> !rsp_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_data)));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ack) |=> (req_ready && !rsp_valid));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ack) |-> busy);

  // R11
  ready_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid);

endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;

  typedef struct {
    logic [31:0] data;
    logic [2:0]  op;
    logic [31:0] b;
    int          acc;
    int          lat;
    int          hold;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_ack = 1'b0;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int issued = 0;
  int finished_cnt = 0;
  int last_acc = 0;
  int ack_cyc = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  muldiv_unit #(.XLEN(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ack(rsp_ack), .busy(busy)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] op,
                                        input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    p = '0;
    case (op)
      3'd0: begin p = ua * ub; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin if (b == 0) return 32'hFFFFFFFF; p = sa / sb; return p[31:0]; end
      3'd5: begin if (b == 0) return 32'hFFFFFFFF; p = ua / ub; return p[31:0]; end
      3'd6: begin if (b == 0) return a; p = sa % sb; return p[31:0]; end
      default: begin if (b == 0) return a; p = ua % ub; return p[31:0]; end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [31:0] b);
    if (op == 3'd0) return "R2";
    if (!op[2]) return "R3";
    if (b == 0) return "R7";
    if (b == 32'hFFFFFFFF && !op[0]) return "R8/R5";
    return "R5";
  endfunction

  // driver: waits for acceptance, then pushes the expected item
  task automatic issue(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input int hold);
    logic took;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op;
    req_a = a;
    req_b = b;
    took = 1'b0;
    while (!took) begin
      #1;
      if (req_ready) begin
        check(busy === 1'b1, "R10 busy on request", {31'd0, busy}, 32'd1);
        took = 1'b1;
      end
      @(posedge clk);
      if (!took) @(negedge clk);
    end
    #1;
    e.data = model(op, a, b);
    e.op = op;
    e.b = b;
    e.acc = cyc;
    e.lat = op[2] ? 32 : 0;
    e.hold = hold;
    q.push_back(e);
    last_acc = cyc;
    issued++;
  endtask

  // requests while the unit is not ready must be ignored
  task automatic poke(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_op = 3'd0;
      req_a = 32'h0BAD0000 + i;
      req_b = 32'h00000003;
      #1;
      check(req_ready === 1'b0, "R11 not ready while running", {31'd0, req_ready}, 32'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops expected items as results appear and acknowledges them
  initial begin : monitor
    exp_t cur;
    logic active;
    logic release_pending;
    logic [31:0] first_data;
    int waited;
    active = 1'b0;
    release_pending = 1'b0;
    waited = 0;
    first_data = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid) begin
        if (!active) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected result", rsp_data, 32'd0);
            cur.hold = 0;
            cur.lat = 0;
            cur.acc = cyc;
            cur.data = rsp_data;
            cur.op = 3'd0;
            cur.b = '0;
          end else begin
            cur = q.pop_front();
          end
          active = 1'b1;
          waited = 0;
          first_data = rsp_data;
          check(rsp_data === cur.data, tag_of(cur.op, cur.b), rsp_data, cur.data);
          check((cyc - cur.acc) == cur.lat, cur.op[2] ? "R6 latency" : "R4 latency",
                cyc - cur.acc, cur.lat);
        end else begin
          check(rsp_data === first_data, "R9 held data", rsp_data, first_data);
        end
        check(busy === 1'b1, "R10 busy while unacknowledged", {31'd0, busy}, 32'd1);
        if (waited == cur.hold) begin
          rsp_ack = 1'b1;
          #1;
          check(busy === 1'b0, "R10 busy low in ack cycle", {31'd0, busy}, 32'd0);
          ack_cyc = cyc;
          release_pending = 1'b1;
          active = 1'b0;
        end else begin
          waited++;
        end
      end else if (release_pending) begin
        rsp_ack = 1'b0;
        check(req_ready === 1'b1, "R9 idle after ack", {31'd0, req_ready}, 32'd1);
        release_pending = 1'b0;
        finished_cnt++;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", finished_cnt, issued);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int coll_ack;
    repeat (3) @(negedge clk);
    #1;
    check(req_ready === 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
    check(rsp_valid === 1'b0, "R1 no result in reset", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(busy === 1'b0, "R1 idle not busy", {31'd0, busy}, 32'd0);
    check(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    check(rsp_valid === 1'b0, "R1 no result after reset", {31'd0, rsp_valid}, 32'd0);

    // R2 low multiply
    issue(3'd0, 32'd7, 32'd6, 0);
    issue(3'd0, 32'hFFFFFFFD, 32'd5, 1);
    issue(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    issue(3'd0, 32'h12345678, 32'h9ABCDEF0, 3);
    // R3 upper multiplies
    issue(3'd1, 32'hFFFFFFFD, 32'd5, 0);
    issue(3'd1, 32'h80000000, 32'h80000000, 1);
    issue(3'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 0);
    issue(3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    issue(3'd2, 32'h80000000, 32'd2, 2);
    issue(3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    issue(3'd3, 32'h80000001, 32'h00010000, 0);
    // R5 divides and remainders
    issue(3'd4, 32'd20, 32'd3, 0);
    issue(3'd4, 32'hFFFFFFEC, 32'd3, 1);
    issue(3'd4, 32'd20, 32'hFFFFFFFD, 0);
    issue(3'd4, 32'hFFFFFFEC, 32'hFFFFFFFD, 0);
    issue(3'd5, 32'hFFFFFFFF, 32'd2, 2);
    issue(3'd6, 32'hFFFFFFEC, 32'd3, 0);
    issue(3'd6, 32'd20, 32'hFFFFFFFD, 0);
    issue(3'd7, 32'hFFFFFFFF, 32'd10, 0);
    issue(3'd5, 32'd3, 32'hFFFFFFFF, 0);
    // R7 zero divisor
    issue(3'd4, 32'd7, 32'd0, 0);
    issue(3'd5, 32'd5, 32'd0, 0);
    issue(3'd6, 32'hFFFFFFF9, 32'd0, 1);
    issue(3'd7, 32'd9, 32'd0, 0);
    // R8 signed overflow
    issue(3'd4, 32'h80000000, 32'hFFFFFFFF, 0);
    issue(3'd6, 32'h80000000, 32'hFFFFFFFF, 0);

    // R11 requests during a running divide are ignored
    issue(3'd4, 32'hFFFF0001, 32'd77, 1);
    poke(8);

    // R11 request held across the acknowledge cycle
    issue(3'd7, 32'd1000, 32'd7, 2);
    issue(3'd0, 32'd11, 32'd13, 0);
    coll_ack = ack_cyc;
    check(last_acc == coll_ack + 2, "R11 accept after ack", last_acc, coll_ack + 2);

    @(negedge clk);
    req_valid = 1'b0;

    while (finished_cnt < issued) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
    check(busy === 1'b0, "R10 idle at end", {31'd0, busy}, 32'd0);
    check(q.size() == 0, "R9 all results seen", q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule